// File: doc/BRIEF.md
# Dither threshold ring

This block holds the digital dither thresholds for a threshold converter. It keeps eight byte entries in a ring, and only the entry at the head of the ring can be accessed at any time. Every accepted access advances the head by one position after the access completes, so successive accesses walk around the ring.

There are two ways to access the ring.

- **Hardware access.** While the active video window is asserted, each rising edge of the sample-and-hold strobe copies the head entry into the threshold output register and then rotates the ring. The threshold register keeps its value until the next hardware access.
- **Software access.** Outside the window, software reads or writes the head entry through a register port, and each access rotates the ring.

Software access attempted inside the window is refused. A refused access leaves the ring untouched and sets a sticky error flag, which software clears by writing 1.

Top module: `dither_ring`

## Requirements
- R1: After reset the head is entry 0, all eight entries hold 0, and `thresh`, `sw_rdata` and `sw_err` are 0.
- R2: A software write (`sw_wr`=1 with `active_win`=0) stores `sw_wdata` into the head entry and advances the head by one.
- R3: A software read (`sw_rd`=1 with `active_win`=0) places the head entry on `sw_rdata` after the next rising clock edge and advances the head by one. `sw_rdata` holds its value until the next accepted read.
- R4: A hardware access happens when `sh_strobe` is 1 in a cycle after a cycle in which it was 0, and `active_win` is 1. It loads the head entry into `thresh` at that clock edge and advances the head by one. A strobe held high causes only one hardware access, and `thresh` is otherwise unchanged.
- R5: A strobe rising edge while `active_win`=0 has no effect: `thresh` and the head do not change.
- R6: A software read or write while `active_win`=1 is ignored. No entry changes, the head does not move, `sw_rdata` does not change, and `sw_err` becomes 1 after that clock edge.
- R7: `sw_err` stays at 1 until `err_clr`=1 is applied. `err_clr` clears it after that clock edge. If a refused access happens in the same cycle as `err_clr`, the flag stays set.
- R8: The head advances modulo 8, so the ninth access after the head was at entry k again reaches entry k.
- R9: A read and a write in the same accepted cycle count as one access. `sw_rdata` receives the old head contents, the head entry takes `sw_wdata`, and the head advances once.
- R10: A hardware access and a refused software access in the same cycle advance the head exactly once. The hardware access completes normally and `sw_err` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| active_win | input | 1 | Active video window; enables hardware access and blocks software access |
| sh_strobe | input | 1 | Sample-and-hold strobe; its rising edge requests a hardware access |
| sw_rd | input | 1 | Software read request for the head entry |
| sw_wr | input | 1 | Software write request for the head entry |
| sw_wdata | input | W | Software write data |
| err_clr | input | 1 | Write-1 clear for the sticky error flag |
| thresh | output | W | Threshold byte from the most recent hardware access |
| sw_rdata | output | W | Data from the most recent accepted software read |
| sw_err | output | 1 | Sticky flag for refused software access |

## Verification
Hardware and software accesses cannot both be accepted in one cycle, because the window level selects which kind is allowed. The bench therefore forces the two to collide: it raises a strobe edge inside the window in the same cycle as a software write request. The expected outcome is one threshold load, one head step and a set error flag, and a later read outside the window shows that the entry was not overwritten.

A second collision is a refused access arriving in the same cycle as an error clear; the flag must stay set. A reference ring model in the bench predicts `thresh`, `sw_rdata` and `sw_err` for every cycle, and each prediction is compared one clock after it is queued.

// File: rtl/dither_ring.sv
module dither_ring #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active_win,
  input  logic         sh_strobe,
  input  logic         sw_rd,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_wdata,
  input  logic         err_clr,
  output logic [W-1:0] thresh,
  output logic [W-1:0] sw_rdata,
  output logic         sw_err
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  ring [DEPTH];
  logic [PW-1:0] head, head_nxt;
  logic          strobe_q;
  logic          hw_hit, sw_req, sw_ok, sw_bad, rotate;

  assign hw_hit   = sh_strobe & ~strobe_q & active_win;
  assign sw_req   = sw_rd | sw_wr;
  assign sw_ok    = sw_req & ~active_win;
  assign sw_bad   = sw_req & active_win;
  assign rotate   = hw_hit | sw_ok;
  assign head_nxt = (head == LAST) ? '0 : head + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      head     <= '0;
      thresh   <= '0;
      sw_rdata <= '0;
      sw_err   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
    end else begin
      strobe_q <= sh_strobe;
      if (hw_hit) thresh <= ring[head];
      if (sw_ok && sw_rd) sw_rdata <= ring[head];
      if (sw_ok && sw_wr) ring[head] <= sw_wdata;
      if (rotate) head <= head_nxt;
      if (sw_bad) sw_err <= 1'b1;
      else if (err_clr) sw_err <= 1'b0;
    end
  end

  assert_thresh_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sh_strobe && !strobe_q && active_win) |=> $stable(thresh));

  assert_outside_win_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_win && !sw_rd && !sw_wr) |=> ($stable(head) && $stable(thresh)));

  assert_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_win && (sw_rd || sw_wr) && !(sh_strobe && !strobe_q))
      |=> ($stable(head) && $stable(sw_rdata) && sw_err));

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_rd && !active_win) |=> $stable(sw_rdata));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_err && !err_clr) |=> sw_err);

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && head == LAST) |=> (head == '0));

  assert_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_strobe && !strobe_q && active_win && (sw_rd || sw_wr))
      |=> (sw_err && head == (($past(head) == LAST) ? '0 : $past(head) + 1'b1)));
endmodule

// File: tb/dither_ring_tb.sv
module dither_ring_tb;
  localparam int W = 8;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic active_win = 1'b0, sh_strobe = 1'b0, sw_rd = 1'b0, sw_wr = 1'b0, err_clr = 1'b0;
  logic [W-1:0] sw_wdata = '0;
  logic [W-1:0] thresh, sw_rdata;
  logic sw_err;

  always #4 clk = ~clk;

  dither_ring #(.DEPTH(DEPTH), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .active_win(active_win), .sh_strobe(sh_strobe),
    .sw_rd(sw_rd), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .err_clr(err_clr),
    .thresh(thresh), .sw_rdata(sw_rdata), .sw_err(sw_err));

  typedef struct {
    logic [W-1:0] thr;
    logic [W-1:0] rd;
    logic         err;
    int           due;
    string        req;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int n_run = 0, n_fail = 0;

  logic [W-1:0] mring [DEPTH];
  int mh = 0;
  logic [W-1:0] mthr = '0, mrd = '0;
  logic merr = 1'b0, mprev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      n_run += 3;
      if (thresh !== it.thr) begin
        n_fail++;
        $display("FAIL %s thresh actual=%0h expected=%0h", it.req, thresh, it.thr);
      end
      if (sw_rdata !== it.rd) begin
        n_fail++;
        $display("FAIL %s sw_rdata actual=%0h expected=%0h", it.req, sw_rdata, it.rd);
      end
      if (sw_err !== it.err) begin
        n_fail++;
        $display("FAIL %s sw_err actual=%0b expected=%0b", it.req, sw_err, it.err);
      end
    end
  end

  task automatic step(input logic rd, input logic wr, input logic [W-1:0] wd,
                      input logic stb, input logic win, input logic clr, input string req);
    item_t it;
    logic hw, swr, swok;
    @(negedge clk);
    sw_rd = rd; sw_wr = wr; sw_wdata = wd; sh_strobe = stb; active_win = win; err_clr = clr;
    hw = stb && !mprev && win;
    swr = rd || wr;
    swok = swr && !win;
    if (hw) mthr = mring[mh];
    if (swok && rd) mrd = mring[mh];
    if (swok && wr) mring[mh] = wd;
    if (hw || swok) mh = (mh + 1) % DEPTH;
    if (swr && win) merr = 1'b1;
    else if (clr) merr = 1'b0;
    mprev = stb;
    it.thr = mthr; it.rd = mrd; it.err = merr; it.due = cyc + 1; it.req = req;
    sb.push_back(it);
  endtask

  task automatic idle(input logic win, input string req);
    step(1'b0, 1'b0, '0, 1'b0, win, 1'b0, req);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mring[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, and the entries read back as zero
    idle(1'b0, "R1");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R1");
    // R2: fill the ring (the head is now at entry 3)
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, W'(8'h10 + i * 8'h11), 1'b0, 1'b0, 1'b0, "R2");
    // R3 and R8: read nine times to show the wrap
    for (int i = 0; i < DEPTH + 1; i++) step(1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R3_R8");
    idle(1'b0, "R3");
    // R4: strobe edges inside the window, one pulse held high
    idle(1'b1, "R4");
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, "R4");
      idle(1'b1, "R4");
    end
    step(1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, "R4");
    step(1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, "R4");
    step(1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, "R4");
    idle(1'b1, "R4");
    // R5: strobe edges outside the window
    idle(1'b0, "R5");
    for (int i = 0; i < 2; i++) begin
      step(1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, "R5");
      idle(1'b0, "R5");
    end
    step(1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R5");
    // R6: software access inside the window is refused
    idle(1'b1, "R6");
    step(1'b0, 1'b1, 8'hEE, 1'b0, 1'b1, 1'b0, "R6");
    step(1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R6");
    idle(1'b0, "R6");
    step(1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R6");
    // R7: the flag is sticky, clears, and a new set beats a clear
    idle(1'b0, "R7");
    step(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1, "R7");
    idle(1'b0, "R7");
    idle(1'b1, "R7");
    step(1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b1, "R7");
    idle(1'b1, "R7");
    step(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1, "R7");
    // R9: read and write in the same cycle
    step(1'b1, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, "R9");
    step(1'b1, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, "R9");
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R9");
    // R10: a strobe edge collides with a refused write
    idle(1'b1, "R10");
    step(1'b0, 1'b1, 8'h77, 1'b1, 1'b1, 1'b0, "R10");
    idle(1'b1, "R10");
    step(1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b0, "R10");
    idle(1'b0, "R10");
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R10");
    idle(1'b0, "R10");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule